// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block resolves one translation miss for a virtual machine that runs under nested paging. The guest owns a four-level page table that maps a guest virtual address to a guest-physical page. Every pointer in that table, starting with the guest root, is itself a guest-physical address. Before the walker can read any guest entry, it must translate the entry's address through a separate four-level host table. The guest's final physical page then needs one more host walk to reach the real machine page. A miss therefore becomes a nested loop of memory reads: four host reads for every guest level (sixteen in all), four guest entry reads and four closing host reads.

The walker is started only by a miss. The surrounding translation cache handles hits and never presents them, so a hit costs the walker nothing. A miss is offered on a valid/ready port. `miss_ready` is high only while the walker is idle, so a miss held valid while the walker is busy waits and is not accepted. Memory reads leave on a valid/ready request port. `req_valid` and `req_addr` are held until `req_ready` is sampled high, and the memory may stall the walker for as long as it likes. Exactly one read is outstanding at a time. The response port has no ready signal: the walker waits for `resp_valid` and takes the entry in that cycle. The block ends a walk with a one-cycle fill strobe or a one-cycle fault strobe. Two counters stay readable after the walk ends: one counts every read, the other counts only the host reads made on behalf of guest table pointers.

Top module: `nested_walker`

## Requirements
- R1: After reset, `busy` is 0, `miss_ready` is 1, and `req_valid`, `fill_valid` and `fault_valid` are 0.
- R2: A miss is accepted in a cycle where `miss_valid` and `miss_ready` are both high. From the next cycle, `busy` is 1 and `miss_ready` is 0 until the walk ends. A miss presented while busy is ignored and does not change the result of the walk in progress.
- R3: While idle, the walker issues no memory request. With `miss_valid` low it stays idle, so a cache hit never reaches memory.
- R4: Requests appear in nested order. For guest stages 4 down to 1, and then for the final guest page, there is a host walk from `host_root` at levels 4 to 1. Each host walk is followed by a guest entry read, except the last one. The 9-bit index at level 4, 3, 2 or 1 is taken from address bits [47:39], [38:30], [29:21] or [20:12]. A host read goes to {table page, index, 3'b000}, using the index of the guest-physical address being translated. A guest read goes to {host page, low 12 bits of the guest entry's guest-physical address}. The guest entry address is {guest table page, index of the virtual address, 3'b000}, and the guest level-4 table page is `guest_root`.
- R5: Only one read is outstanding. `req_valid` stays high with `req_addr` unchanged until `req_ready` is sampled high. No new request is raised until `resp_valid` has returned the entry.
- R6: In a successful walk, `fill_valid` pulses for one cycle. `fill_ppn` is the page from the last host entry, `fill_vpn` is bits [47:12] of the accepted virtual address, and `fill_asid` is the accepted address-space tag. `busy` is already 0 in that cycle.
- R7: The counters clear when a miss is accepted. `walk_refs` counts accepted requests. `nest_refs` counts accepted host requests that serve a guest table level. After a successful walk they read 24 and 16.
- R8: Bit 0 of an entry is its present bit. A non-present entry stops the walk: `fault_valid` pulses for one cycle, `fault_host` is 1 for a host entry and 0 for a guest entry, and no further request is made. The counters hold the references made up to and including the faulting one.
- R9: An entry's next page number is taken from bits [47:12]. Bits [63:48] and [11:1] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| miss_gva | input | 48 | Guest virtual address that missed |
| miss_asid | input | 8 | Address-space tag of the missing VM |
| guest_root | input | 36 | Guest-physical page of the guest level-4 table, sampled on acceptance |
| host_root | input | 36 | Host page of the host level-4 table, sampled on acceptance |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 48 | Host physical byte address of the entry to read |
| resp_valid | input | 1 | Read data returned |
| resp_data | input | 64 | Table entry read |
| busy | output | 1 | Walk in progress |
| fill_valid | output | 1 | One-cycle strobe: walk succeeded |
| fill_vpn | output | 36 | Guest virtual page of the fill |
| fill_asid | output | 8 | Address-space tag of the fill |
| fill_ppn | output | 36 | Final host physical page |
| fault_valid | output | 1 | One-cycle strobe: walk faulted |
| fault_host | output | 1 | Fault was in a host entry (1) or a guest entry (0) |
| walk_refs | output | 5 | Reads issued in the latest walk |
| nest_refs | output | 5 | Host reads serving guest table levels in the latest walk |

## Verification
The assertions assume that memory raises `resp_valid` only while a read is outstanding, and exactly once per accepted request. The bench's memory responder keeps to this. It answers each accepted request with one response after a random delay, and it inserts random request stalls. It also checks every request address against a walk computed in the bench. Entry contents are a hash of the read address mixed with a per-walk salt, and a chosen reference number is made non-present so that faults can be placed at either level of the walk.

// File: rtl/nw_pkg.sv
package nw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HREQ  = 3'd1,
    ST_HWAIT = 3'd2,
    ST_GREQ  = 3'd3,
    ST_GWAIT = 3'd4
  } nw_state_e;
endpackage

// File: rtl/nw_idx_sel.sv
module nw_idx_sel #(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int SEL_W      = 3
) (
  input  logic [PAGE_SHIFT+LEVELS*IDX_W-1:0] addr,
  input  logic [SEL_W-1:0]                   sel,
  output logic [IDX_W-1:0]                   idx
);
  localparam int ADDR_W = PAGE_SHIFT + LEVELS * IDX_W;

  logic [LEVELS-1:0][IDX_W-1:0] slices;

  for (genvar i = 0; i < LEVELS; i++) begin : g_slice
    assign slices[i] = addr[ADDR_W-1-i*IDX_W -: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (sel == SEL_W'(i)) idx = slices[i];
    end
  end

  logic unused_low;
  assign unused_low = ^addr[PAGE_SHIFT-1:0];
endmodule

// File: rtl/nw_ref_counter.sv
module nw_ref_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fire,
  input  logic             nest_phase,
  output logic [CNT_W-1:0] walk_refs,
  output logic [CNT_W-1:0] nest_refs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_refs <= '0;
      nest_refs <= '0;
    end else if (clear) begin
      walk_refs <= '0;
      nest_refs <= '0;
    end else if (fire) begin
      walk_refs <= walk_refs + 1'b1;
      if (nest_phase) nest_refs <= nest_refs + 1'b1;
    end
  end
endmodule

// File: rtl/nw_ctrl.sv
module nw_ctrl
  import nw_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_W      = 64,
  parameter int ASID_W     = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     miss_valid,
  output logic                                     miss_ready,
  input  logic [PAGE_SHIFT+LEVELS*IDX_W-1:0]        miss_gva,
  input  logic [ASID_W-1:0]                        miss_asid,
  input  logic [LEVELS*IDX_W-1:0]                  guest_root,
  input  logic [LEVELS*IDX_W-1:0]                  host_root,
  output logic                                     req_valid,
  input  logic                                     req_ready,
  output logic [PAGE_SHIFT+LEVELS*IDX_W-1:0]        req_addr,
  input  logic                                     resp_valid,
  input  logic [PTE_W-1:0]                         resp_data,
  output logic                                     busy,
  output logic                                     fill_valid,
  output logic [LEVELS*IDX_W-1:0]                  fill_vpn,
  output logic [ASID_W-1:0]                        fill_asid,
  output logic [LEVELS*IDX_W-1:0]                  fill_ppn,
  output logic                                     fault_valid,
  output logic                                     fault_host,
  output logic                                     start,
  output logic                                     req_fire,
  output logic                                     nest_phase
);
  localparam int ADDR_W = PAGE_SHIFT + LEVELS * IDX_W;
  localparam int PPN_W  = ADDR_W - PAGE_SHIFT;
  localparam int ENT_SH = PAGE_SHIFT - IDX_W;
  localparam int LV_W   = $clog2(LEVELS);
  localparam int GS_W   = $clog2(LEVELS + 1);

  nw_state_e          st;
  logic [GS_W-1:0]    gstage;
  logic [LV_W-1:0]    hlvl;
  logic [ADDR_W-1:0]  tgt;
  logic [ADDR_W-1:0]  gva;
  logic [PPN_W-1:0]   hbase;
  logic [PPN_W-1:0]   hroot;
  logic [PPN_W-1:0]   gpage;
  logic [ASID_W-1:0]  asid;
  logic [IDX_W-1:0]   hidx;
  logic [IDX_W-1:0]   gidx;
  logic [ADDR_W-1:0]  gidx_src;
  logic [GS_W-1:0]    gidx_sel;
  logic [PPN_W-1:0]   ent_ppn;
  logic               ent_present;
  logic               last_host;
  logic               final_stage;

  assign ent_ppn     = resp_data[ADDR_W-1:PAGE_SHIFT];
  assign ent_present = resp_data[0];
  assign last_host   = (hlvl == LV_W'(LEVELS - 1));
  assign final_stage = (gstage == GS_W'(LEVELS));

  assign gidx_src = (st == ST_IDLE) ? miss_gva : gva;
  assign gidx_sel = (st == ST_IDLE) ? '0 : gstage + 1'b1;

  nw_idx_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .SEL_W(LV_W)) u_hidx (
    .addr(tgt), .sel(hlvl), .idx(hidx)
  );

  nw_idx_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .SEL_W(GS_W)) u_gidx (
    .addr(gidx_src), .sel(gidx_sel), .idx(gidx)
  );

  assign busy       = (st != ST_IDLE);
  assign miss_ready = (st == ST_IDLE);
  assign start      = miss_valid && (st == ST_IDLE);
  assign req_valid  = (st == ST_HREQ) || (st == ST_GREQ);
  assign req_fire   = req_valid && req_ready;
  assign nest_phase = (st == ST_HREQ) && !final_stage;
  assign req_addr   = (st == ST_GREQ) ? {gpage, tgt[PAGE_SHIFT-1:0]}
                                      : {hbase, hidx, {ENT_SH{1'b0}}};
  assign fill_vpn   = gva[ADDR_W-1:PAGE_SHIFT];
  assign fill_asid  = asid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      gstage      <= '0;
      hlvl        <= '0;
      tgt         <= '0;
      gva         <= '0;
      hbase       <= '0;
      hroot       <= '0;
      gpage       <= '0;
      asid        <= '0;
      fill_valid  <= 1'b0;
      fill_ppn    <= '0;
      fault_valid <= 1'b0;
      fault_host  <= 1'b0;
    end else begin
      fill_valid  <= 1'b0;
      fault_valid <= 1'b0;
      case (st)
        ST_IDLE: if (miss_valid) begin
          gva    <= miss_gva;
          asid   <= miss_asid;
          hroot  <= host_root;
          hbase  <= host_root;
          gstage <= '0;
          hlvl   <= '0;
          tgt    <= {guest_root, gidx, {ENT_SH{1'b0}}};
          st     <= ST_HREQ;
        end
        ST_HREQ: if (req_ready) st <= ST_HWAIT;
        ST_HWAIT: if (resp_valid) begin
          if (!ent_present) begin
            fault_valid <= 1'b1;
            fault_host  <= 1'b1;
            st          <= ST_IDLE;
          end else if (!last_host) begin
            hbase <= ent_ppn;
            hlvl  <= hlvl + 1'b1;
            st    <= ST_HREQ;
          end else if (final_stage) begin
            fill_valid <= 1'b1;
            fill_ppn   <= ent_ppn;
            st         <= ST_IDLE;
          end else begin
            gpage <= ent_ppn;
            st    <= ST_GREQ;
          end
        end
        ST_GREQ: if (req_ready) st <= ST_GWAIT;
        ST_GWAIT: if (resp_valid) begin
          if (!ent_present) begin
            fault_valid <= 1'b1;
            fault_host  <= 1'b0;
            st          <= ST_IDLE;
          end else begin
            tgt    <= {ent_ppn, gidx, {ENT_SH{1'b0}}};
            gstage <= gstage + 1'b1;
            hlvl   <= '0;
            hbase  <= hroot;
            st     <= ST_HREQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{resp_data[PTE_W-1:ADDR_W], resp_data[PAGE_SHIFT-1:1], gva[PAGE_SHIFT-1:0]};
endmodule

// File: rtl/nested_walker.sv
module nested_walker #(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_W      = 64,
  parameter int ASID_W     = 8,
  localparam int ADDR_W    = PAGE_SHIFT + LEVELS * IDX_W,
  localparam int PPN_W     = ADDR_W - PAGE_SHIFT,
  localparam int CNT_W     = $clog2(LEVELS * (LEVELS + 2) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_gva,
  input  logic [ASID_W-1:0] miss_asid,
  input  logic [PPN_W-1:0]  guest_root,
  input  logic [PPN_W-1:0]  host_root,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              resp_valid,
  input  logic [PTE_W-1:0]  resp_data,
  output logic              busy,
  output logic              fill_valid,
  output logic [PPN_W-1:0]  fill_vpn,
  output logic [ASID_W-1:0] fill_asid,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              fault_valid,
  output logic              fault_host,
  output logic [CNT_W-1:0]  walk_refs,
  output logic [CNT_W-1:0]  nest_refs
);
  logic start;
  logic req_fire;
  logic nest_phase;

  nw_ctrl #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .PTE_W(PTE_W), .ASID_W(ASID_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_gva(miss_gva), .miss_asid(miss_asid),
    .guest_root(guest_root), .host_root(host_root),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .busy(busy),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
    .fault_valid(fault_valid), .fault_host(fault_host),
    .start(start), .req_fire(req_fire), .nest_phase(nest_phase)
  );

  nw_ref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clear(start), .fire(req_fire), .nest_phase(nest_phase),
    .walk_refs(walk_refs), .nest_refs(nest_refs)
  );
endmodule

// File: rtl/nw_checker.sv
module nw_checker #(
  parameter int LEVELS = 4,
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic              fill_valid,
  input logic              fault_valid,
  input logic [CNT_W-1:0]  walk_refs,
  input logic [CNT_W-1:0]  nest_refs
);
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(LEVELS * (LEVELS + 2));
  localparam logic [CNT_W-1:0] NEST  = CNT_W'(LEVELS * LEVELS);

  // R2: a walk begins only from an offered miss while ready
  assert_busy_from_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(miss_valid) && $past(miss_ready));

  // R3: no memory traffic while idle
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R5: a stalled request holds its address
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R5: no request while a response is due back in the same cycle
  assert_single_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_valid);

  // R6: fill ends the walk and excludes a fault
  assert_fill_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !busy && !fault_valid);

  // R7: a full walk made the nominal number of references
  assert_fill_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (walk_refs == TOTAL) && (nest_refs == NEST));

  // R8: a fault ends the walk after at least one and at most all references
  assert_fault_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !busy && (walk_refs != '0) && (walk_refs <= TOTAL) && (nest_refs <= walk_refs));
endmodule

bind nested_walker nw_checker #(.LEVELS(LEVELS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready), .busy(busy),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
  .fill_valid(fill_valid), .fault_valid(fault_valid), .walk_refs(walk_refs), .nest_refs(nest_refs)
);

// File: tb/nested_walker_bench.sv
module nested_walker_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        miss_valid;
  logic        miss_ready;
  logic [47:0] miss_gva;
  logic [7:0]  miss_asid;
  logic [35:0] guest_root;
  logic [35:0] host_root;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_addr;
  logic        resp_valid;
  logic [63:0] resp_data;
  logic        busy;
  logic        fill_valid;
  logic [35:0] fill_vpn;
  logic [7:0]  fill_asid;
  logic [35:0] fill_ppn;
  logic        fault_valid;
  logic        fault_host;
  logic [4:0]  walk_refs;
  logic [4:0]  nest_refs;

  nested_walker u_nested_walker (.*);

  int          n_tests = 0;
  int          n_fail  = 0;
  int          ref_n   = 0;
  int          fault_at = 0;
  int          addr_bad = 0;
  logic [63:0] salt = 64'h0;
  logic [47:0] exp_addr [0:31];
  int          exp_n;
  int          exp_nest;
  bit          exp_fault;
  bit          exp_host;
  logic [35:0] exp_ppn;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Entry content for the k-th reference (1-based), R9 layout
  function automatic logic [63:0] entry(input logic [47:0] a, input int k);
    logic [63:0] h;
    h = ({16'h0, a} * 64'h9E3779B97F4A7C15) ^ salt;
    return {16'hA5C3, h[47:12], 11'h7FE, (k != fault_at)};
  endfunction

  function automatic logic [8:0] idx(input logic [47:0] a, input int l);
    return a[47-9*l -: 9];
  endfunction

  task automatic model(input logic [47:0] gva, input logic [35:0] groot, input logic [35:0] hroot);
    logic [35:0] gppn;
    logic [35:0] base;
    logic [47:0] tgt;
    logic [47:0] a;
    logic [63:0] e;
    int          n;
    bit          stop;
    n = 0; exp_nest = 0; exp_fault = 0; exp_host = 0; exp_ppn = '0; stop = 0;
    gppn = groot;
    for (int s = 0; s <= 4 && !stop; s++) begin
      tgt = (s < 4) ? {gppn, idx(gva, s), 3'b000} : {gppn, 12'h000};
      base = hroot;
      for (int l = 0; l < 4 && !stop; l++) begin
        a = {base, idx(tgt, l), 3'b000};
        n++; exp_addr[n] = a; e = entry(a, n);
        if (s < 4) exp_nest++;
        if (!e[0]) begin exp_fault = 1; exp_host = 1; stop = 1; end
        else base = e[47:12];
      end
      if (!stop) begin
        if (s == 4) exp_ppn = base;
        else begin
          a = {base, tgt[11:0]};
          n++; exp_addr[n] = a; e = entry(a, n);
          if (!e[0]) begin exp_fault = 1; exp_host = 0; stop = 1; end
          else gppn = e[47:12];
        end
      end
    end
    exp_n = n;
  endtask

  // Memory responder: random stalls, one read at a time
  initial begin
    req_ready = 1'b0; resp_valid = 1'b0; resp_data = '0;
    forever begin
      logic [47:0] a;
      @(negedge clk);
      req_ready = 1'b0; resp_valid = 1'b0;
      if (req_valid) begin
        repeat ($urandom % 3) @(negedge clk);
        a = req_addr;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        ref_n++;
        if (ref_n > 31 || a != exp_addr[ref_n]) addr_bad++;
        repeat ($urandom % 3) @(negedge clk);
        resp_data  = entry(a, ref_n);
        resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
      end
    end
  end

  task automatic run_walk(input logic [47:0] gva, input logic [7:0] asid,
                          input logic [35:0] groot, input logic [35:0] hroot,
                          input int fat, input bit poke);
    int waited;
    fault_at = fat; ref_n = 0; addr_bad = 0;
    salt = {$urandom, $urandom};
    model(gva, groot, hroot);
    @(negedge clk);
    miss_gva = gva; miss_asid = asid; guest_root = groot; host_root = hroot;
    miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(busy == 1'b1 && miss_ready == 1'b0, "R2 busy after accept", {busy, miss_ready}, 2'b10);
    if (poke) begin
      miss_valid = 1'b1; miss_gva = ~gva; miss_asid = ~asid;
      guest_root = ~groot; host_root = ~hroot;
      repeat (3) @(negedge clk);
      miss_valid = 1'b0;
    end
    waited = 0;
    while (!(fill_valid || fault_valid) && waited < 3000) begin
      @(negedge clk); waited++;
    end
    chk(fault_valid == exp_fault && fill_valid == !exp_fault, "R8 outcome kind",
        {fill_valid, fault_valid}, {!exp_fault, exp_fault});
    if (exp_fault) begin
      chk(fault_host == exp_host, "R8 fault level", fault_host, exp_host);
    end else begin
      chk(fill_ppn == exp_ppn, "R6 fill ppn", fill_ppn, exp_ppn);
      chk(fill_vpn == gva[47:12] && fill_asid == asid, "R6 fill tag",
          {fill_asid, fill_vpn}, {asid, gva[47:12]});
    end
    chk(busy == 1'b0, "R6 busy cleared at end", busy, 0);
    chk(walk_refs == 5'(exp_n), "R7 walk_refs", walk_refs, exp_n);
    chk(nest_refs == 5'(exp_nest), "R7 nest_refs", nest_refs, exp_nest);
    chk(addr_bad == 0, "R4 request address order", addr_bad, 0);
    begin
      int seen = 0;
      repeat (4) begin
        @(negedge clk);
        if (req_valid || fill_valid || fault_valid) seen++;
      end
      chk(seen == 0, "R8 quiet after walk", seen, 0);
    end
  endtask

  initial begin
    process::self().srandom(32'h5EED_0007);
    rst_n = 1'b0; miss_valid = 1'b0; miss_gva = '0; miss_asid = '0;
    guest_root = '0; host_root = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && miss_ready == 1 && req_valid == 0 && fill_valid == 0 && fault_valid == 0,
        "R1 reset state", {busy, miss_ready, req_valid, fill_valid, fault_valid}, 5'b01000);

    begin
      int seen = 0;
      repeat (10) begin @(negedge clk); if (req_valid) seen++; end
      chk(seen == 0, "R3 no request without miss", seen, 0);
    end

    // directed: full success, then faults at chosen references (R8, R7)
    run_walk(48'h0000_0000_0000, 8'h01, 36'h0, 36'h0, 0, 0);
    run_walk(48'hFFFF_FFFF_F000, 8'hFE, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 0, 0);
    run_walk(48'h1234_5678_9000, 8'h22, 36'h0_0001_0000, 36'h0_0002_0000, 1, 0);
    run_walk(48'h1234_5678_9000, 8'h23, 36'h0_0001_0000, 36'h0_0002_0000, 5, 0);
    run_walk(48'h8765_4321_0000, 8'h24, 36'h0_0003_0000, 36'h0_0004_0000, 20, 0);
    run_walk(48'h8765_4321_0000, 8'h25, 36'h0_0003_0000, 36'h0_0004_0000, 24, 0);
    // R2: miss offered while busy is ignored
    run_walk(48'hA5A5_5A5A_3000, 8'h77, 36'h1_2345_6789, 36'h9_8765_4321, 0, 1);

    for (int t = 0; t < 30; t++) begin
      logic [47:0] g;
      g = {$urandom, $urandom};
      run_walk(g, 8'($urandom), 36'({$urandom, $urandom}), 36'({$urandom, $urandom}),
               int'($urandom % 32), bit'($urandom % 4 == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule